// File: doc/BRIEF.md
# DMA Channel Status Register Bank

This block is the software-visible bookkeeping front of a multi-channel DMA controller with up to 32 channels. For every channel it keeps a small state machine with three states: IDLE (code 2'b10), PENDING (code 2'b01) and ACTIVE (code 2'b11). It also keeps a control word per channel and one interrupt summary bit per channel. Software sees the state codes packed two bits per channel in a low and a high status word. A poll word carries one bit per channel that is 1 exactly while the channel is IDLE.

The channel state machine moves as follows.
- IDLE to PENDING: a software-start request for the channel, if its enable and software-start-enable bits are both set.
- PENDING to ACTIVE: a start pulse from the transfer engine while the channel is enabled.
- ACTIVE to PENDING: any control write to the channel while its transfer is unfinished.
- PENDING to IDLE: a write that clears enable after the channel's transfer has finished.
- Any state to IDLE: a write with the channel-clear bit set, or a done pulse from the engine.

The arbiter reads the per-channel pending and enable outputs. The engine reports start, done and interrupt events by channel number.

The control word of channel c sits at byte address 4*c, with these bits:

| Bit | Field | Access |
|---|---|---|
| 0 | enable | read/write |
| 1 | channel clear | self-clearing, reads 0 |
| 2 | software-start enable | read/write |
| 3 | block-interrupt mask | read/write |
| 4 | half-interrupt mask | read/write |
| 5 | block cause | write 1 to clear |
| 6 | half cause | write 1 to clear |

The shared registers are:

| Byte address | Register |
|---|---|
| 0x80 | status, channels 0 to 15 |
| 0x84 | status, channels 16 to 31 |
| 0x88 | interrupt summary |
| 0x8C | poll |
| 0x90 | start register A |
| 0x94 | start register B |

Top module: `dma_status_bank`

## Requirements
- R1: After reset both status words read 0xAAAAAAAA, poll reads all ones, the summary reads 0, and every control word has both masks set (bits 3, 4). Software-start enable (bit 2) is set only for channels 0 and 1, so channel 0 reads 0x1C and channel 2 reads 0x18.
- R2: The 2-bit code of channel c sits at bits 2*(c mod 16) of the low status word for c < 16, and of the high word otherwise. IDLE is 2'b10, PENDING is 2'b01 and ACTIVE is 2'b11.
- R3: Poll bit c is 1 exactly when channel c is IDLE.
- R4: Writing a channel number to start register A or B makes that channel PENDING only when its enable and software-start-enable bits are both set. Otherwise the write has no effect on the channel. Each start register reads back the last number written to it.
- R5: A control write with the clear bit set forces enable to 0 and the state to IDLE, and marks the transfer finished. The clear bit always reads 0.
- R6: A control write with bit 5 or bit 6 set clears those cause bits and clears the channel's summary bit.
- R7: An engine interrupt event sets the selected cause (block or half) and the summary bit only when the matching mask is 0. irq_out is the OR of all summary bits.
- R8: An engine start pulse moves a PENDING, enabled channel to ACTIVE. An engine done pulse moves the channel to IDLE and clears its enable.
- R9: Clearing enable while the transfer is unfinished leaves the channel PENDING. Clearing enable after it has finished makes the channel IDLE. Setting enable with no unfinished transfer leaves an IDLE channel IDLE.
- R10: ch_pending[c] is 1 only when channel c is PENDING and enabled. ch_enable[c] shows the enable bit.
- R11: A misaligned address, or one outside the decoded map, reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when bus_rd is low |
| eng_start_valid | input | 1 | Engine begins a transfer on eng_start_ch |
| eng_start_ch | input | 5 | Channel for the start event |
| eng_done_valid | input | 1 | Engine finished the transfer on eng_done_ch |
| eng_done_ch | input | 5 | Channel for the done event |
| eng_irq_valid | input | 1 | Engine interrupt event |
| eng_irq_half | input | 1 | 1 for a half-transfer event, 0 for a block event |
| eng_irq_ch | input | 5 | Channel for the interrupt event |
| ch_pending | output | NUM_CH | Channel is PENDING and enabled |
| ch_enable | output | NUM_CH | Channel enable bits |
| irq_out | output | 1 | OR of the summary bits |

## Verification
On every cycle, the assertions check four things:
- the poll bit agrees with the IDLE code of each channel;
- a clear write or an engine done event lands in IDLE with enable low;
- a qualifying software start lands in PENDING;
- a masked interrupt event leaves the cause unchanged and a cause write clears the summary.

Only the bench scenarios can show the rest:
- the packing of codes into the two status words;
- the reset values of the control words;
- the paused-transfer path through PENDING;
- that misaligned and unmapped accesses are ignored.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;

    localparam int MAX_CH  = 32;
    localparam int SEL_W   = 5;
    localparam int CTLH_W  = 7;

    // Control word bit positions.
    localparam int B_EN    = 0;
    localparam int B_CLR   = 1;
    localparam int B_SWEN  = 2;
    localparam int B_BMASK = 3;
    localparam int B_HMASK = 4;
    localparam int B_BCAUS = 5;
    localparam int B_HCAUS = 6;

    // Status codes, as software sees them.
    localparam logic [1:0] CODE_IDLE = 2'b10;
    localparam logic [1:0] CODE_PEND = 2'b01;
    localparam logic [1:0] CODE_ACT  = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PENDING = 2'd1,
        ST_ACTIVE  = 2'd2
    } chan_state_e;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CTLH,
        REG_STA_LO,
        REG_STA_HI,
        REG_IRQ,
        REG_POLL,
        REG_START_A,
        REG_START_B
    } reg_kind_e;

endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
    import dma_stat_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [SEL_W-1:0]  ch
);
    localparam int WORD_W = ADDR_W - 2;

    logic              aligned;
    logic [WORD_W-1:0] word;

    assign aligned = (addr[1:0] == 2'b00);
    assign word    = addr[ADDR_W-1:2];

    always_comb begin
        kind = REG_NONE;
        ch   = word[SEL_W-1:0];
        if (aligned) begin
            if (word < WORD_W'(MAX_CH)) begin
                if (word < WORD_W'(NUM_CH)) kind = REG_CTLH;
            end else begin
                case (word)
                    WORD_W'(MAX_CH + 0): kind = REG_STA_LO;
                    WORD_W'(MAX_CH + 1): kind = REG_STA_HI;
                    WORD_W'(MAX_CH + 2): kind = REG_IRQ;
                    WORD_W'(MAX_CH + 3): kind = REG_POLL;
                    WORD_W'(MAX_CH + 4): kind = REG_START_A;
                    WORD_W'(MAX_CH + 5): kind = REG_START_B;
                    default:             kind = REG_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_stat_pkg::*;
#(
    parameter bit SWEN_RST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTLH_W-1:0] ctl_wdata,
    input  logic              sw_kick,
    input  logic              eng_start,
    input  logic              eng_done,
    input  logic              irq_blk,
    input  logic              irq_half,
    output logic [1:0]        stat_code,
    output logic              poll_o,
    output logic [CTLH_W-1:0] ctlh_rd,
    output logic              pend_o,
    output logic              en_o,
    output logic              sum_o
);
    chan_state_e state_q, state_d;
    logic en_q, en_d, swen_q, swen_d, bmask_q, bmask_d, hmask_q, hmask_d;
    logic bcause_q, bcause_d, hcause_q, hcause_d;
    logic unf_q, unf_d, sum_q, sum_d, poll_q;

    // Next-state and field logic.
    always_comb begin
        state_d  = state_q;
        en_d     = en_q;
        unf_d    = unf_q;
        swen_d   = swen_q;
        bmask_d  = bmask_q;
        hmask_d  = hmask_q;
        if (ctl_wr) begin
            swen_d  = ctl_wdata[B_SWEN];
            bmask_d = ctl_wdata[B_BMASK];
            hmask_d = ctl_wdata[B_HMASK];
        end
        if (ctl_wr && ctl_wdata[B_CLR]) begin
            state_d = ST_IDLE;
            en_d    = 1'b0;
            unf_d   = 1'b0;
        end else if (eng_done) begin
            state_d = ST_IDLE;
            en_d    = 1'b0;
            unf_d   = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ctl_wr) begin
                        en_d = ctl_wdata[B_EN];
                    end else if (sw_kick && en_q && swen_q) begin
                        state_d = ST_PENDING;
                    end
                end
                ST_PENDING: begin
                    if (eng_start && en_q) begin
                        state_d = ST_ACTIVE;
                        unf_d   = 1'b1;
                    end else if (ctl_wr) begin
                        en_d = ctl_wdata[B_EN];
                        if (!ctl_wdata[B_EN] && !unf_q) state_d = ST_IDLE;
                    end
                end
                ST_ACTIVE: begin
                    if (ctl_wr) begin
                        en_d    = ctl_wdata[B_EN];
                        state_d = ST_PENDING;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Interrupt causes and summary: an event in the same cycle wins over a clear.
    always_comb begin
        bcause_d = bcause_q & ~(ctl_wr & ctl_wdata[B_BCAUS]);
        hcause_d = hcause_q & ~(ctl_wr & ctl_wdata[B_HCAUS]);
        sum_d    = sum_q;
        if (ctl_wr && (ctl_wdata[B_BCAUS] || ctl_wdata[B_HCAUS])) sum_d = 1'b0;
        if (irq_blk && !bmask_q) begin
            bcause_d = 1'b1;
            sum_d    = 1'b1;
        end
        if (irq_half && !hmask_q) begin
            hcause_d = 1'b1;
            sum_d    = 1'b1;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            en_q     <= 1'b0;
            unf_q    <= 1'b0;
            swen_q   <= SWEN_RST;
            bmask_q  <= 1'b1;
            hmask_q  <= 1'b1;
            bcause_q <= 1'b0;
            hcause_q <= 1'b0;
            sum_q    <= 1'b0;
            poll_q   <= 1'b1;
        end else begin
            state_q  <= state_d;
            en_q     <= en_d;
            unf_q    <= unf_d;
            swen_q   <= swen_d;
            bmask_q  <= bmask_d;
            hmask_q  <= hmask_d;
            bcause_q <= bcause_d;
            hcause_q <= hcause_d;
            sum_q    <= sum_d;
            poll_q   <= (state_d == ST_IDLE);
        end
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            ST_IDLE:    stat_code = CODE_IDLE;
            ST_PENDING: stat_code = CODE_PEND;
            ST_ACTIVE:  stat_code = CODE_ACT;
            default:    stat_code = 2'b00;
        endcase
        pend_o  = (state_q == ST_PENDING) && en_q;
        en_o    = en_q;
        sum_o   = sum_q;
        poll_o  = poll_q;
        ctlh_rd = {hcause_q, bcause_q, hmask_q, bmask_q, swen_q, 1'b0, en_q};
    end

    assert_clear_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[B_CLR]) |=> (state_q == ST_IDLE && !en_q));

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> (state_q == ST_IDLE && !en_q));

    assert_kick_pends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_kick && en_q && swen_q && state_q == ST_IDLE && !ctl_wr && !eng_done)
        |=> state_q == ST_PENDING);

    assert_w1c_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && (ctl_wdata[B_BCAUS] || ctl_wdata[B_HCAUS]) && !irq_blk && !irq_half)
        |=> !sum_q);

    assert_masked_blk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_blk && bmask_q && !ctl_wr) |=> $stable(bcause_q));

endmodule

// File: rtl/dma_status_bank.sv
module dma_status_bank
    import dma_stat_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              eng_start_valid,
    input  logic [SEL_W-1:0]  eng_start_ch,
    input  logic              eng_done_valid,
    input  logic [SEL_W-1:0]  eng_done_ch,
    input  logic              eng_irq_valid,
    input  logic              eng_irq_half,
    input  logic [SEL_W-1:0]  eng_irq_ch,
    output logic [NUM_CH-1:0] ch_pending,
    output logic [NUM_CH-1:0] ch_enable,
    output logic              irq_out
);
    localparam int HALF_CH = MAX_CH / 2;

    reg_kind_e          kind;
    logic [SEL_W-1:0]   sel_ch;
    logic [SEL_W-1:0]   start_a_q, start_b_q;
    logic [1:0]         code_w [NUM_CH];
    logic [CTLH_W-1:0]  ctlh_w [NUM_CH];
    logic [NUM_CH-1:0]  poll_w, sum_w;
    logic [31:0]        sta_lo, sta_hi;
    logic               kick_any;

    dma_reg_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_decode (
        .addr (bus_addr),
        .kind (kind),
        .ch   (sel_ch)
    );

    assign kick_any = bus_wr && (kind == REG_START_A || kind == REG_START_B);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_a_q <= '0;
            start_b_q <= '0;
        end else if (bus_wr) begin
            if (kind == REG_START_A) start_a_q <= bus_wdata[SEL_W-1:0];
            if (kind == REG_START_B) start_b_q <= bus_wdata[SEL_W-1:0];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dma_chan_ctl #(.SWEN_RST(c < 2)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_wr    (bus_wr && kind == REG_CTLH && sel_ch == SEL_W'(c)),
            .ctl_wdata (bus_wdata[CTLH_W-1:0]),
            .sw_kick   (kick_any && bus_wdata[SEL_W-1:0] == SEL_W'(c)),
            .eng_start (eng_start_valid && eng_start_ch == SEL_W'(c)),
            .eng_done  (eng_done_valid && eng_done_ch == SEL_W'(c)),
            .irq_blk   (eng_irq_valid && !eng_irq_half && eng_irq_ch == SEL_W'(c)),
            .irq_half  (eng_irq_valid && eng_irq_half && eng_irq_ch == SEL_W'(c)),
            .stat_code (code_w[c]),
            .poll_o    (poll_w[c]),
            .ctlh_rd   (ctlh_w[c]),
            .pend_o    (ch_pending[c]),
            .en_o      (ch_enable[c]),
            .sum_o     (sum_w[c])
        );

        if (c < HALF_CH) begin : g_lo
            assign sta_lo[2*c +: 2] = code_w[c];
        end else begin : g_hi
            assign sta_hi[2*(c-HALF_CH) +: 2] = code_w[c];
        end

        assert_poll_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
            poll_w[c] == (code_w[c] == CODE_IDLE));
    end

    for (genvar c = NUM_CH; c < MAX_CH; c++) begin : g_pad
        if (c < HALF_CH) begin : g_lo
            assign sta_lo[2*c +: 2] = 2'b00;
        end else begin : g_hi
            assign sta_hi[2*(c-HALF_CH) +: 2] = 2'b00;
        end
    end

    assign irq_out = |sum_w;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (kind)
                REG_CTLH:    bus_rdata = 32'(ctlh_w[sel_ch]);
                REG_STA_LO:  bus_rdata = sta_lo;
                REG_STA_HI:  bus_rdata = sta_hi;
                REG_IRQ:     bus_rdata = 32'(sum_w);
                REG_POLL:    bus_rdata = 32'(poll_w);
                REG_START_A: bus_rdata = 32'(start_a_q);
                REG_START_B: bus_rdata = 32'(start_b_q);
                default:     bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: tb/dma_status_bank_bench.sv
module dma_status_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_start_valid = 1'b0, eng_done_valid = 1'b0;
    logic        eng_irq_valid = 1'b0, eng_irq_half = 1'b0;
    logic [4:0]  eng_start_ch = '0, eng_done_ch = '0, eng_irq_ch = '0;
    logic [31:0] ch_pending, ch_enable;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dma_status_bank u_dma_status_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_start_valid(eng_start_valid), .eng_start_ch(eng_start_ch),
        .eng_done_valid(eng_done_valid), .eng_done_ch(eng_done_ch),
        .eng_irq_valid(eng_irq_valid), .eng_irq_half(eng_irq_half),
        .eng_irq_ch(eng_irq_ch), .ch_pending(ch_pending),
        .ch_enable(ch_enable), .irq_out(irq_out)
    );

    // Entry: {is_read, addr[7:0], data_or_expected[31:0], req[3:0]}.
    localparam int NVEC = 24;
    localparam logic [44:0] VEC [NVEC] = '{
        {1'b1, 8'h00, 32'h0000001C, 4'd1},   // R1 control word reset, ch0
        {1'b1, 8'h08, 32'h00000018, 4'd1},   // R1 ch2 has no software start enable
        {1'b1, 8'h80, 32'hAAAAAAAA, 4'd1},   // R1 low status word
        {1'b1, 8'h84, 32'hAAAAAAAA, 4'd1},   // R1 high status word
        {1'b1, 8'h8C, 32'hFFFFFFFF, 4'd3},   // R3 all poll bits set
        {1'b1, 8'h88, 32'h00000000, 4'd1},   // R1 summary clear
        {1'b0, 8'h00, 32'h0000001D, 4'd9},   // enable ch0
        {1'b1, 8'h80, 32'hAAAAAAAA, 4'd9},   // R9 enable alone keeps IDLE
        {1'b0, 8'h90, 32'h00000000, 4'd4},   // start ch0 via A
        {1'b1, 8'h80, 32'hAAAAAAA9, 4'd4},   // R4 ch0 PENDING
        {1'b1, 8'h8C, 32'hFFFFFFFE, 4'd3},   // R3 poll bit 0 drops
        {1'b0, 8'h94, 32'h00000002, 4'd4},   // start ch2, not enabled
        {1'b1, 8'h80, 32'hAAAAAAA9, 4'd4},   // R4 ignored
        {1'b0, 8'h08, 32'h0000001D, 4'd4},   // enable ch2 with software start
        {1'b0, 8'h94, 32'h00000002, 4'd4},
        {1'b1, 8'h80, 32'hAAAAAA99, 4'd2},   // R2 ch0 and ch2 fields
        {1'b1, 8'h94, 32'h00000002, 4'd4},   // R4 start B read back
        {1'b0, 8'h00, 32'h0000001E, 4'd5},   // clear ch0
        {1'b1, 8'h80, 32'hAAAAAA9A, 4'd5},   // R5 ch0 IDLE
        {1'b1, 8'h00, 32'h0000001C, 4'd5},   // R5 clear bit and enable read 0
        {1'b0, 8'h03, 32'h0000001D, 4'd11},  // misaligned write
        {1'b1, 8'h03, 32'h00000000, 4'd11},  // R11 misaligned read
        {1'b1, 8'h98, 32'h00000000, 4'd11},  // R11 unmapped read
        {1'b1, 8'h00, 32'h0000001C, 4'd11}   // R11 ch0 untouched
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic eng(input int kind, input logic [4:0] ch, input logic half);
        @(negedge clk);
        if (kind == 0) begin eng_start_valid = 1'b1; eng_start_ch = ch; end
        if (kind == 1) begin eng_done_valid = 1'b1; eng_done_ch = ch; end
        if (kind == 2) begin eng_irq_valid = 1'b1; eng_irq_ch = ch; eng_irq_half = half; end
        @(negedge clk);
        eng_start_valid = 1'b0; eng_done_valid = 1'b0; eng_irq_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R10 reset pending", ch_pending, 32'h0);
        check("R7 reset irq_out", 32'(irq_out), 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][44]) begin
                rd(VEC[i][43:36], v);
                check($sformatf("vec %0d R%0d", i, VEC[i][3:0]), v, VEC[i][35:4]);
            end else begin
                wr(VEC[i][43:36], VEC[i][35:4]);
            end
        end

        // R10: ch2 PENDING and enabled.
        check("R10 ch2 pending out", ch_pending, 32'h4);
        // R8: start ch2.
        eng(0, 5'd2, 1'b0);
        rd(8'h80, v); check("R8 ch2 ACTIVE", v, 32'hAAAAAABA);
        check("R10 active not pending", ch_pending, 32'h0);
        rd(8'h8C, v); check("R3 poll while active", v, 32'hFFFFFFFB);
        // R9: disable while unfinished stays PENDING.
        wr(8'h08, 32'h0000001C);
        rd(8'h80, v); check("R9 paused PENDING", v, 32'hAAAAAA9A);
        check("R10 disabled pending out", ch_pending, 32'h0);
        check("R10 enable out", ch_enable, 32'h0);
        wr(8'h08, 32'h0000001D);
        check("R9 re-enable pending out", ch_pending, 32'h4);
        // R7: masked event does nothing.
        eng(2, 5'd2, 1'b0);
        rd(8'h88, v); check("R7 masked summary", v, 32'h0);
        wr(8'h08, 32'h00000015);
        eng(2, 5'd2, 1'b0);
        rd(8'h08, v); check("R7 block cause set", v, 32'h00000035);
        rd(8'h88, v); check("R7 summary bit", v, 32'h4);
        check("R7 irq_out high", 32'(irq_out), 32'h1);
        // R6: write-one-to-clear.
        wr(8'h08, 32'h00000035);
        rd(8'h08, v); check("R6 cause cleared", v, 32'h00000015);
        rd(8'h88, v); check("R6 summary cleared", v, 32'h0);
        check("R6 irq_out low", 32'(irq_out), 32'h0);
        // R8: start then done.
        eng(0, 5'd2, 1'b0);
        eng(1, 5'd2, 1'b0);
        rd(8'h80, v); check("R8 done IDLE", v, 32'hAAAAAAAA);
        check("R8 done clears enable", ch_enable, 32'h0);
        // R9: disable after finish goes IDLE from PENDING.
        wr(8'h08, 32'h00000005);
        wr(8'h90, 32'h00000002);
        wr(8'h08, 32'h00000004);
        rd(8'h80, v); check("R9 finished disable IDLE", v, 32'hAAAAAAAA);
        // R2: high word, ch17.
        wr(8'h44, 32'h00000005);
        wr(8'h90, 32'h00000011);
        rd(8'h84, v); check("R2 ch17 high word", v, 32'hAAAAAAA6);
        rd(8'h8C, v); check("R3 poll ch17", v, 32'hFFFDFFFF);
        rd(8'h90, v); check("R4 start A read back", v, 32'h00000011);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule